// File: doc/BRIEF.md
# Two-Minute Stopwatch Core

This block keeps the elapsed time of a stopwatch that shows minutes and seconds from 0:00 up to 1:59. After 1:59 it returns to 0:00. It is driven by the system clock and by a one-cycle pulse that arrives once per second. Two further single-cycle controls act on it. The first flips the watch between running and halted. The second zeroes the displayed time.

The time is held as three cascaded stages on one clock:

- a decimal seconds-ones digit (0 to 9);
- a seconds-tens digit (0 to 5);
- a one-bit minutes stage.

A stage moves only when every stage below it is at its last value and an accepted second pulse arrives. Each carry acts as a clock enable and never as a clock. A control unit turns the raw inputs into two strobes for the datapath: "zero everything" and "advance one second".

The digit outputs and the running indication go straight to display or status logic elsewhere in the chip. Display multiplexing, segment decoding, debouncing and generation of the second pulse are done outside this block.

Top module: `sec_watch_top`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, all digit outputs are 0 and the running output is 0.
- R2: A high cycle on the run-toggle input inverts the running output, visible after the next rising clock edge.
- R3: A second pulse accepted while running advances the seconds-ones digit by one, visible after the next edge. The digit goes from 9 back to 0.
- R4: The seconds-tens digit advances only on an accepted pulse that finds the ones digit at 9. It goes from 5 back to 0 and otherwise holds.
- R5: An accepted pulse at 0:59 gives 1:00, and an accepted pulse at 1:59 gives 0:00. The minutes output changes only on an accepted pulse at x:59.
- R6: Second pulses that arrive while the running output is 0 leave all digits unchanged.
- R7: A high cycle on the clear input zeroes all digits after the next edge, even when a second pulse arrives in the same cycle. Clear leaves the running state as it was, except for a toggle given in the same cycle.
- R8: When a second pulse and a run-toggle arrive in the same cycle, the running state before that edge decides whether the pulse is counted.
- R9: The seconds-ones digit never exceeds 9, the seconds-tens digit never exceeds 5, and the minutes value never exceeds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every stage updates on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| secTick_i | input | 1 | One-cycle pulse, once per second |
| clear_i | input | 1 | One-cycle synchronous clear of all digits |
| runToggle_i | input | 1 | One-cycle pulse that flips running and halted |
| secOnes_o | output | 4 | Seconds-ones digit, binary 0 to 9 |
| secTens_o | output | 4 | Seconds-tens digit, binary 0 to 5 |
| minutes_o | output | 1 | Minutes value, 0 or 1 |
| running_o | output | 1 | 1 while the watch counts pulses |

## Verification
Every result of this block is a register output. A second pulse, clear or toggle given in cycle n therefore shows on the ports exactly one rising edge later. This holds for all three stages, including a carry that travels through every stage at once, as at 1:59 to 0:00.

The bench drives inputs on the falling edge and samples on the following falling edge, after exactly one rising edge. Each check therefore sees the first cycle where the new value is due. A stalled or late carry would fail the check. The check on the reset state is made in the cycle after reset is released.

// File: rtl/swatch_pkg.sv
package swatch_pkg;
  // Strobes from the control unit to the digit datapath
  typedef struct packed {
    logic clrStb;   // zero all stages on the next edge
    logic advStb;   // advance one second on the next edge
  } swStrobe_t;
endpackage

// File: rtl/swatch_digit.sv
// One modulo-MOD stage with synchronous clear priority over enable
module swatch_digit #(
  parameter int MOD = 10,
  parameter int W   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] value_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  logic [W-1:0] valueQ;
  logic [W-1:0] valueD;

  always_comb begin
    valueD = valueQ;
    if (clr_i)            valueD = '0;
    else if (en_i)        valueD = (valueQ == LAST) ? '0 : valueQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valueQ <= '0;
    else        valueQ <= valueD;
  end

  assign value_o = valueQ;

  // R3/R4: an enabled stage at its last value returns to zero
  p_digit_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && valueQ == LAST) |=> (valueQ == '0));

  // R9: the stage never leaves its legal range
  p_digit_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valueQ <= LAST));

  // R7: clear gives zero on the next edge
  p_digit_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (valueQ == '0));
endmodule

// File: rtl/swatch_ctrl.sv
// Run flag and strobe generation
module swatch_ctrl
  import swatch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      secTick_i,
  input  logic      clear_i,
  input  logic      runToggle_i,
  output swStrobe_t strobe_o,
  output logic      running_o
);
  logic runFlag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           runFlag <= 1'b0;
    else if (runToggle_i) runFlag <= ~runFlag;
  end

  // Pulse judged against the run state held before this edge (R8)
  always_comb begin
    strobe_o.clrStb = clear_i;
    strobe_o.advStb = secTick_i && runFlag && !clear_i;
  end

  assign running_o = runFlag;

  // R2: a toggle pulse flips the run state
  p_run_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    runToggle_i |=> (runFlag != $past(runFlag)));

  // R7: clear alone leaves the run state alone
  p_clear_keeps_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && !runToggle_i) |=> $stable(runFlag));
endmodule

// File: rtl/swatch_datapath.sv
// Cascaded ones / tens / minutes stages, carries used as enables
module swatch_datapath
  import swatch_pkg::*;
#(
  parameter int DIGIT_W  = 4,
  parameter int ONES_MOD = 10,
  parameter int TENS_MOD = 6,
  parameter int MIN_MOD  = 2,
  parameter int MIN_W    = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  swStrobe_t          strobe_i,
  output logic [DIGIT_W-1:0] secOnes_o,
  output logic [DIGIT_W-1:0] secTens_o,
  output logic [MIN_W-1:0]   minutes_o
);
  localparam logic [DIGIT_W-1:0] ONES_LAST = DIGIT_W'(ONES_MOD - 1);
  localparam logic [DIGIT_W-1:0] TENS_LAST = DIGIT_W'(TENS_MOD - 1);

  logic onesCarry;
  logic tensCarry;

  assign onesCarry = strobe_i.advStb && (secOnes_o == ONES_LAST);
  assign tensCarry = onesCarry && (secTens_o == TENS_LAST);

  swatch_digit #(.MOD(ONES_MOD), .W(DIGIT_W)) onesStage_i (
    .clk(clk), .rst_n(rst_n), .clr_i(strobe_i.clrStb),
    .en_i(strobe_i.advStb), .value_o(secOnes_o));

  swatch_digit #(.MOD(TENS_MOD), .W(DIGIT_W)) tensStage_i (
    .clk(clk), .rst_n(rst_n), .clr_i(strobe_i.clrStb),
    .en_i(onesCarry), .value_o(secTens_o));

  swatch_digit #(.MOD(MIN_MOD), .W(MIN_W)) minStage_i (
    .clk(clk), .rst_n(rst_n), .clr_i(strobe_i.clrStb),
    .en_i(tensCarry), .value_o(minutes_o));

  // R4: tens holds unless the ones digit is wrapping
  p_tens_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i.clrStb && !(strobe_i.advStb && secOnes_o == ONES_LAST))
      |=> $stable(secTens_o));

  // R5: minutes moves only when seconds roll over from x:59
  p_min_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i.clrStb &&
     !(strobe_i.advStb && secOnes_o == ONES_LAST && secTens_o == TENS_LAST))
      |=> $stable(minutes_o));
endmodule

// File: rtl/sec_watch_top.sv
module sec_watch_top
  import swatch_pkg::*;
#(
  parameter int DIGIT_W  = 4,
  parameter int ONES_MOD = 10,
  parameter int TENS_MOD = 6,
  parameter int MIN_MOD  = 2,
  parameter int MIN_W    = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               secTick_i,
  input  logic               clear_i,
  input  logic               runToggle_i,
  output logic [DIGIT_W-1:0] secOnes_o,
  output logic [DIGIT_W-1:0] secTens_o,
  output logic [MIN_W-1:0]   minutes_o,
  output logic               running_o
);
  swStrobe_t strobe;

  swatch_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .secTick_i(secTick_i), .clear_i(clear_i),
    .runToggle_i(runToggle_i), .strobe_o(strobe), .running_o(running_o));

  swatch_datapath #(
    .DIGIT_W(DIGIT_W), .ONES_MOD(ONES_MOD), .TENS_MOD(TENS_MOD),
    .MIN_MOD(MIN_MOD), .MIN_W(MIN_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe),
    .secOnes_o(secOnes_o), .secTens_o(secTens_o), .minutes_o(minutes_o));

  // R6: halted watch keeps its time
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !clear_i) |=> ($stable(secOnes_o) && $stable(secTens_o)
                                  && $stable(minutes_o)));
endmodule

// File: tb/sec_watch_top_tb.sv
module sec_watch_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // Vector: [12]tick [11]toggle [10]clear [9]expRun [8]expMin [7:4]expTens [3:0]expOnes
  localparam logic [12:0] VEC [NVEC] = '{
    13'b1_0_0_0_0_0000_0000,  // R6 pulse while halted
    13'b0_1_0_1_0_0000_0000,  // R2 start
    13'b1_0_0_1_0_0000_0001,  // R3
    13'b1_0_0_1_0_0000_0010,  // R3
    13'b1_1_0_0_0_0000_0011,  // R8 pulse counted, then halt
    13'b1_0_0_0_0_0000_0011,  // R6
    13'b0_1_0_1_0_0000_0011,  // R2 restart
    13'b1_0_1_1_0_0000_0000,  // R7 clear beats pulse, still running
    13'b1_0_0_1_0_0000_0001,  // R3
    13'b0_1_1_0_0_0000_0000,  // R7 clear with toggle
    13'b0_1_0_1_0_0000_0000,  // R2
    13'b1_0_0_1_0_0000_0001   // R3
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic secTick_i = 1'b0;
  logic clear_i = 1'b0;
  logic runToggle_i = 1'b0;
  logic [3:0] secOnes_o;
  logic [3:0] secTens_o;
  logic [0:0] minutes_o;
  logic running_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_watch_top dut_i (
    .clk(clk), .rst_n(rst_n), .secTick_i(secTick_i), .clear_i(clear_i),
    .runToggle_i(runToggle_i), .secOnes_o(secOnes_o), .secTens_o(secTens_o),
    .minutes_o(minutes_o), .running_o(running_o));

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chkTime(input string req, input int secs, input int run);
    chk(req, int'(secOnes_o), secs % 10);
    chk(req, int'(secTens_o), (secs / 10) % 6);
    chk(req, int'(minutes_o), secs / 60);
    chk(req, int'(running_o), run);
  endtask

  // Called at a falling edge; returns at the falling edge after one rising edge
  task automatic step(input logic t, input logic s, input logic c);
    secTick_i = t; runToggle_i = s; clear_i = c;
    @(posedge clk);
    @(negedge clk);
    secTick_i = 1'b0; runToggle_i = 1'b0; clear_i = 1'b0;
  endtask

  initial begin
    int secs;
    @(negedge clk);
    @(negedge clk);
    chkTime("R1 during reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chkTime("R1 after reset", 0, 0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][12], VEC[i][11], VEC[i][10]);
      chk($sformatf("vec%0d ones R3", i), int'(secOnes_o), int'(VEC[i][3:0]));
      chk($sformatf("vec%0d tens R4", i), int'(secTens_o), int'(VEC[i][7:4]));
      chk($sformatf("vec%0d min R5", i),  int'(minutes_o), int'(VEC[i][8]));
      chk($sformatf("vec%0d run R2", i),  int'(running_o), int'(VEC[i][9]));
    end

    // Full sweep: running, from 0:00 through 1:59 and back to 0:00
    step(1'b0, 1'b0, 1'b1);
    chkTime("R7 clear before sweep", 0, 1);
    secs = 0;
    for (int k = 0; k < 125; k++) begin
      step(1'b1, 1'b0, 1'b0);
      secs = (secs + 1) % 120;
      chkTime((secs == 0) ? "R5 rollover 1:59 to 0:00" :
              (secs == 60) ? "R5 0:59 to 1:00" :
              (secs % 10 == 0) ? "R4 tens carry" : "R3 ones step",
              secs, 1);
      if (k % 7 == 3) begin
        step(1'b0, 1'b0, 1'b0);   // idle cycle keeps time
        chkTime("R3 hold without pulse", secs, 1);
      end
    end
    chk("R9 range ones", int'(secOnes_o <= 4'd9), 1);

    // Halt at 0:05, pulses ignored
    step(1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b0, 1'b0);
      chkTime("R6 halted pulses", secs, 0);
    end

    // Reset mid-count
    step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chkTime("R1 reset mid-run", 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule